// File: doc/BRIEF.md
# Dual-Channel Converter Capture Interface

This block sits behind a dual 8-bit pipelined converter whose two channels, I and Q, are updated from one common sample clock. The block runs on a system clock. A one-cycle sample strobe, already brought into that clock domain, marks each converter clock edge. On every strobe the block registers both code buses together. It can optionally turn the offset-binary codes into two's complement. The result is a registered bundle of I word, Q word, sample index and a valid pulse.

The converter's output word always lags its analog sample by exactly six converter clocks. The block therefore tags each word with the running strobe count minus six, so that the index names the sample instant that produced the word. The first twenty words after reset are dropped, because the converter's dynamic circuits are still settling. The converter also needs a minimum conversion rate. If no strobe arrives for a configurable number of system clocks, the block treats the converter clock as stalled and restarts the discard period. The index keeps running through such a restart.

Top module: `adc_dual_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `out_i`, `out_q` and `out_idx` are all 0.
- R2: A strobe sampled on a clock edge loads both channels' codes at that same edge, and the outputs show them right after it. `out_valid` is high for exactly that one cycle, and only when the word is kept.
- R3: The first 20 strobes after reset give `out_valid` = 0. The 21st strobe gives `out_valid` = 1.
- R4: `out_idx` equals the number of strobes since reset, counting the current one, minus 7, modulo 2^32. This is the strobe ordinal minus the latency of 6, counted from 0. Consecutive kept words carry consecutive indices.
- R5: With `twos_mode` = 0, `out_i` and `out_q` equal the captured codes unchanged (offset binary: 0x80 is just above zero, 0x7F is just below zero).
- R6: With `twos_mode` = 1, bit 7 of each captured code is inverted and the other bits are unchanged. So 0x80→0x00, 0x7F→0xFF, 0xFF→0x7F and 0x00→0x80.
- R7: If 64 or more consecutive system clocks pass without a strobe, the next 20 strobes give `out_valid` = 0 and the 21st gives 1. `out_idx` is unaffected by this restart.
- R8: A gap of at most 63 strobe-free clocks between two strobes does not restart the discard period.
- R9: In a cycle without a strobe, `out_i`, `out_q` and `out_idx` keep their values, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle pulse per converter sample clock edge |
| i_code | input | 8 | I-channel code from the converter (offset binary) |
| q_code | input | 8 | Q-channel code from the converter (offset binary) |
| twos_mode | input | 1 | 1 selects two's-complement output, 0 passes offset binary |
| out_valid | output | 1 | One-cycle pulse: this word is kept |
| out_i | output | 8 | Captured I word |
| out_q | output | 8 | Captured Q word |
| out_idx | output | 32 | Sample index of the captured pair |

## Verification
The assertions assume that `smp_stb` is a clean single-cycle pulse in the system domain. They also assume that `twos_mode` changes only while no strobe is being captured, since the format check compares an output bit with the code sampled one edge earlier. The bench drives every strobe as a one-cycle pulse, always followed by at least one quiet cycle. It changes the code inputs and the mode only away from strobe edges. It sizes its idle gaps to land exactly one clock on each side of the stall limit.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } fmt_e;

    localparam int unsigned DEF_CODE_W   = 8;
    localparam int unsigned DEF_IDX_W    = 32;
    localparam int unsigned DEF_LATENCY  = 6;
    localparam int unsigned DEF_BLANK    = 20;
    localparam int unsigned DEF_STALL    = 64;

endpackage

// File: rtl/adc_cap_lane.sv
module adc_cap_lane
    import adc_cap_pkg::*;
#(
    parameter int unsigned DW = DEF_CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  fmt_e          fmt,
    input  logic [DW-1:0] code,
    output logic [DW-1:0] word
);

    typedef struct packed {
        logic [DW-1:0] word;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            if (fmt == FMT_TWOS) begin
                st_d.word = {~code[DW-1], code[DW-2:0]};
            end else begin
                st_d.word = code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

    // R6: sign bit flipped relative to the sampled code
    p_twos_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && fmt == FMT_TWOS) |=> (word[DW-1] != $past(code[DW-1])));

    // R5: offset mode passes the code through
    p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && fmt == FMT_OFFSET) |=> (word == $past(code)));

    // R6: lower bits never altered
    p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (word[DW-2:0] == $past(code[DW-2:0])));

endmodule

// File: rtl/adc_cap_blank.sv
module adc_cap_blank
    import adc_cap_pkg::*;
#(
    parameter int unsigned BLANK       = DEF_BLANK,
    parameter int unsigned STALL_LIMIT = DEF_STALL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic keep
);

    localparam int unsigned BW = $clog2(BLANK + 1);
    localparam int unsigned SW = $clog2(STALL_LIMIT + 1);
    localparam logic [BW-1:0] BLANK_V = BW'(BLANK);
    localparam logic [SW-1:0] STALL_V = SW'(STALL_LIMIT);

    typedef struct packed {
        logic [BW-1:0] blank;
        logic [SW-1:0] idle;
    } blank_st_t;

    blank_st_t     st_d, st_q;
    logic          stall;
    logic [BW-1:0] base;

    always_comb begin
        st_d  = st_q;
        stall = (st_q.idle == STALL_V);
        base  = stall ? '0 : st_q.blank;
        keep  = stb && !stall && (st_q.blank == BLANK_V);
        if (stb && (base != BLANK_V)) begin
            st_d.blank = base + 1'b1;
        end else begin
            st_d.blank = base;
        end
        if (stb) begin
            st_d.idle = '0;
        end else if (!stall) begin
            st_d.idle = st_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: idle counter saturates at the stall limit
    p_idle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idle <= STALL_V);

    // R3: discard count never exceeds its target
    p_blank_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.blank <= BLANK_V);

    // R7: a stall with no strobe leaves the discard count at zero
    p_stall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !stb) |=> (st_q.blank == '0));

endmodule

// File: rtl/adc_cap_index.sv
module adc_cap_index
    import adc_cap_pkg::*;
#(
    parameter int unsigned IW      = DEF_IDX_W,
    parameter int unsigned LATENCY = DEF_LATENCY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    output logic [IW-1:0] tag
);

    typedef struct packed {
        logic [IW-1:0] cnt;
    } idx_st_t;

    idx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tag = st_q.cnt - IW'(LATENCY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: counter advances once per strobe
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R4: counter is still without a strobe
    p_idx_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(st_q.cnt));

endmodule

// File: rtl/adc_dual_capture.sv
module adc_dual_capture
    import adc_cap_pkg::*;
#(
    parameter int unsigned DW          = DEF_CODE_W,
    parameter int unsigned IW          = DEF_IDX_W,
    parameter int unsigned LATENCY     = DEF_LATENCY,
    parameter int unsigned BLANK       = DEF_BLANK,
    parameter int unsigned STALL_LIMIT = DEF_STALL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic [DW-1:0] i_code,
    input  logic [DW-1:0] q_code,
    input  logic          twos_mode,
    output logic          out_valid,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q,
    output logic [IW-1:0] out_idx
);

    localparam int unsigned NLANE = 2;

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] idx;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          keep;
    logic [IW-1:0] tag;
    fmt_e          fmt;
    logic [DW-1:0] lane_in  [NLANE];
    logic [DW-1:0] lane_out [NLANE];

    assign fmt        = fmt_e'(twos_mode);
    assign lane_in[0] = i_code;
    assign lane_in[1] = q_code;

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            adc_cap_lane #(.DW(DW)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .stb   (smp_stb),
                .fmt   (fmt),
                .code  (lane_in[g]),
                .word  (lane_out[g])
            );
        end
    endgenerate

    adc_cap_blank #(.BLANK(BLANK), .STALL_LIMIT(STALL_LIMIT)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb),
        .keep  (keep)
    );

    adc_cap_index #(.IW(IW), .LATENCY(LATENCY)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb),
        .tag   (tag)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = keep;
        if (smp_stb) begin
            st_d.idx = tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_idx   = st_q.idx;
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];

    // R2: a kept word always stems from a strobe one edge earlier
    p_valid_from_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_stb));

    // R9: outputs hold between strobes
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(out_i) && $stable(out_q) && $stable(out_idx)));

    // R2: no valid after a strobe-free cycle
    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !out_valid);

endmodule

// File: tb/tb_adc_dual_capture.sv
module tb_adc_dual_capture;

    localparam int STALL = 64;
    localparam int NBLNK = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [7:0]  i_code = '0;
    logic [7:0]  q_code = '0;
    logic        twos_mode = 1'b0;
    logic        out_valid;
    logic [7:0]  out_i;
    logic [7:0]  out_q;
    logic [31:0] out_idx;

    int compared = 0;
    int mismatched = 0;
    int nstb = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_dual_capture dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .i_code    (i_code),
        .q_code    (q_code),
        .twos_mode (twos_mode),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_idx   (out_idx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] conv(input logic [7:0] c);
        return twos_mode ? {~c[7], c[6:0]} : c;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one strobe, then one quiet cycle in which the outputs are checked
    task automatic send(input logic [7:0] iv, input logic [7:0] qv,
                        input bit exp_v, input string req);
        @(negedge clk);
        smp_stb = 1'b1;
        i_code  = iv;
        q_code  = qv;
        nstb++;
        @(negedge clk);
        smp_stb = 1'b0;
        chk(req, "valid", {31'd0, out_valid}, {31'd0, exp_v});
        if (exp_v) begin
            chk(req, "i", {24'd0, out_i}, {24'd0, conv(iv)});
            chk(req, "q", {24'd0, out_q}, {24'd0, conv(qv)});
            chk(req, "idx", out_idx, 32'(nstb - 7));
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        chk("R1", "valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "i", {24'd0, out_i}, 32'd0);
        chk("R1", "q", {24'd0, out_q}, 32'd0);
        chk("R1", "idx", out_idx, 32'd0);
        rst_n = 1'b1;
        idle(1);
        chk("R1", "valid after release", {31'd0, out_valid}, 32'd0);
        nstb = 0;
    endtask

    task automatic t_blank;
        for (int k = 0; k < NBLNK; k++) send(8'(k), 8'(255 - k), 1'b0, "R3");
        send(8'h3C, 8'hC3, 1'b1, "R3");
    endtask

    task automatic t_offset;
        send(8'h80, 8'h7F, 1'b1, "R5");
        send(8'hFF, 8'h00, 1'b1, "R5");
        send(8'hA5, 8'h5A, 1'b1, "R2");
        send(8'h01, 8'hFE, 1'b1, "R4");
    endtask

    task automatic t_hold;
        logic [7:0]  pi;
        logic [7:0]  pq;
        logic [31:0] px;
        send(8'h66, 8'h99, 1'b1, "R2");
        pi = out_i;
        pq = out_q;
        px = out_idx;
        i_code = 8'h12;
        q_code = 8'h34;
        idle(1);
        chk("R2", "valid one cycle", {31'd0, out_valid}, 32'd0);
        idle(3);
        chk("R9", "i held", {24'd0, out_i}, {24'd0, pi});
        chk("R9", "q held", {24'd0, out_q}, {24'd0, pq});
        chk("R9", "idx held", out_idx, px);
    endtask

    task automatic t_twos;
        twos_mode = 1'b1;
        send(8'h80, 8'h7F, 1'b1, "R6");
        chk("R6", "0x80", {24'd0, out_i}, 32'h00);
        chk("R6", "0x7F", {24'd0, out_q}, 32'hFF);
        send(8'hFF, 8'h00, 1'b1, "R6");
        chk("R6", "0xFF", {24'd0, out_i}, 32'h7F);
        chk("R6", "0x00", {24'd0, out_q}, 32'h80);
        twos_mode = 1'b0;
    endtask

    task automatic t_gap_short;
        idle(STALL - 2);
        send(8'h11, 8'h22, 1'b1, "R8");
    endtask

    task automatic t_stall;
        idle(STALL - 1);
        for (int k = 0; k < NBLNK; k++) send(8'(k + 40), 8'(k + 90), 1'b0, "R7");
        send(8'h77, 8'h88, 1'b1, "R7");
        send(8'h78, 8'h89, 1'b1, "R4");
    endtask

    initial begin
        t_reset;
        t_blank;
        t_offset;
        t_hold;
        t_twos;
        t_gap_short;
        t_stall;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule